// File: doc/BRIEF.md
# Frame SECDED Check Unit

This unit checks one 101-word configuration frame (32 bits per word, 3232 bits in all) as it streams past, one word per accepted cycle. One word of the frame, word 50, holds the check bits of a Hamming code in its low 13 bits. The unit folds every word into a running 12-bit position syndrome and a running overall parity bit. When the 101st word is accepted it decodes the two into a verdict: the frame is clean, it has one flipped bit (whose word and bit index are reported), or it has a double (uncorrectable) error.

A control pulse `sof` starts each frame and clears the accumulators. Words enter over a valid/ready handshake. The unit applies back-pressure only between frames: `in_ready` is low from reset until the first `sof`, during any `sof` cycle, and from the acceptance of the 101st word until the next `sof`. Words offered while `in_ready` is low are not taken and have no effect. The verdict appears on plain status pins, with a one-cycle `res_valid` strobe, and stays on those pins until the next verdict. Repair of the frame and storage of frames belong to the surrounding logic. With three or more flips in one frame the verdict is not guaranteed to be correct.

Top module: `frame_ecc_check`

## Requirements
- R1: A word is taken when `in_valid` and `in_ready` are both high. `in_index` gives its word number, 0 to 100. The 101st word taken after `sof` completes the frame, and idle cycles between words do not change the result.
- R2: `in_ready` is 0 after reset, 0 in any cycle in which `sof` is 1, and 0 from the cycle after the frame's last word until the next `sof`. A `sof` discards any partly received frame and arms the unit for a new frame.
- R3: Only bits 12:0 of word 50 are reserved. Bits 11:0 hold the XOR of the positions of all data bits that are 1. Bit 12 makes the parity of all 3232 bits even. Bits 31:13 of word 50 are ordinary data.
- R4: A data bit at word w, bit b has flat index f = w*32+b. If f has two or more 1 bits, its position is f. Otherwise, if f < 256, its position is 0xF00|f. Otherwise its position is 0xE00|(f>>4).
- R5: `res_valid` is high for exactly one cycle, the cycle after the 101st word is taken. `res_status`, `res_word` and `res_bit` change only in that cycle and hold their value until the next result.
- R6: `res_status` encodes 0 = clean, 1 = single-bit error, 2 = double error. The value 3 never appears. After reset `res_status` is 0.
- R7: A frame whose check bits match its data gives status 0.
- R8: A single flipped data bit gives status 1, with `res_word` and `res_bit` equal to the word and bit index of that bit.
- R9: A single flip of check bit k (word 50, bit k, k < 12) gives status 1 at word 50, bit k. A single flip of the parity bit gives status 1 at word 50, bit 12.
- R10: Any two flipped bits give status 2. Whenever the status is not 1, `res_word` and `res_bit` are 0.
- R11: If the parity mismatches but the syndrome maps to no bit of the frame, the status is 2. Such a syndrome is one that maps to the reserved bits 12:0 of word 50 or to a position no bit has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start-of-frame pulse; clears the accumulators |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The unit will take the offered word |
| in_word | input | 32 | Frame word |
| in_index | input | 7 | Word number of `in_word` within the frame |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_status | output | 2 | 0 clean, 1 single, 2 double |
| res_word | output | 7 | Word index of the single flipped bit |
| res_bit | output | 5 | Bit index of the single flipped bit |

## Verification
The bench flips bits whose flat index has one or zero 1 bits, such as word 0 bit 0 and word 64 bit 0. A design that left those positions unmapped would collide with a check-bit syndrome and report word 50 instead. It flips check bits, the parity bit, and data bits inside word 50. A design that mixed up the reserved field would report the wrong location or a double error. It builds three-flip frames whose syndrome lands in the reserved field or beyond the frame. A design that trusted any parity mismatch would report a single error at a bit that does not exist. It also offers words outside the ready window, restarts a frame in the middle with `sof`, and sends a frame with idle gaps. A design that counted words it never accepted would complete a frame early or hide the result.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  localparam int WORD_W        = 32;
  localparam int IDX_W         = 7;
  localparam int BIT_W         = 5;
  localparam int POS_W         = IDX_W + BIT_W;
  localparam int CHK_BITS      = 12;
  localparam int FRAME_WORDS_D = 101;
  localparam int ECC_WORD_D    = 50;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_SINGLE = 2'd1,
    ST_DOUBLE = 2'd2
  } fecc_status_e;

  // Position of a data bit from its flat index; weights of zero or one
  // are moved above the frame so no data bit aliases a check bit.
  function automatic logic [POS_W-1:0] pos_of(input logic [POS_W-1:0] f);
    if ($countones(f) > 1)      return f;
    else if (f < POS_W'(256))   return POS_W'(12'hF00) | f;
    else                        return POS_W'(12'hE00) | (f >> 4);
  endfunction

  // Inverse of pos_of: {valid, flat index}.
  function automatic logic [POS_W:0] unpos(input logic [POS_W-1:0] s,
                                          input int frame_bits,
                                          input int rsv_lo);
    logic [POS_W:0] r;
    r = '0;
    if (s[11:8] == 4'hF && $countones(s[7:0]) <= 1)
      r = {1'b1, 4'h0, s[7:0]};
    else if (s[11:8] == 4'hE && $countones(s[7:0]) == 1 && s[3:0] == 4'h0)
      r = {1'b1, s[7:0], 4'h0};
    else if (int'(s) < frame_bits && $countones(s) > 1 &&
             !(int'(s) >= rsv_lo && int'(s) <= rsv_lo + CHK_BITS))
      r = {1'b1, s};
    return r;
  endfunction
endpackage

// File: rtl/fecc_pos_xor.sv
module fecc_pos_xor
  import fecc_pkg::*;
#(
  parameter int ECC_WORD = ECC_WORD_D
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  index,
  output logic [POS_W-1:0]  syn_part,
  output logic              par_part
);
  logic [POS_W-1:0] term [WORD_W];
  logic             is_ecc;

  assign is_ecc = (index == IDX_W'(ECC_WORD));

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam logic [BIT_W-1:0] BI = BIT_W'(b);
    logic keep;
    if (b <= CHK_BITS) begin : g_rsv
      assign keep = word[b] & ~is_ecc;
    end else begin : g_dat
      assign keep = word[b];
    end
    assign term[b] = keep ? pos_of({index, BI}) : '0;
  end

  always_comb begin
    syn_part = is_ecc ? word[CHK_BITS-1:0] : '0;
    for (int b = 0; b < WORD_W; b++) syn_part = syn_part ^ term[b];
  end

  assign par_part = ^word;
endmodule

// File: rtl/fecc_accum.sv
module fecc_accum
  import fecc_pkg::*;
#(
  parameter int FRAME_WORDS = FRAME_WORDS_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [POS_W-1:0] syn_part,
  input  logic             par_part,
  output logic [POS_W-1:0] syn_next,
  output logic             par_next,
  output logic             frame_done
);
  localparam int CNT_W = $clog2(FRAME_WORDS);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [POS_W-1:0] syn_q;
  logic             par_q;
  logic             take;

  assign in_ready   = armed_q & ~sof;
  assign take       = in_valid & in_ready;
  assign syn_next   = syn_q ^ syn_part;
  assign par_next   = par_q ^ par_part;
  assign frame_done = take && (cnt_q == CNT_W'(FRAME_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      syn_q   <= '0;
      par_q   <= 1'b0;
    end else if (sof) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      syn_q   <= '0;
      par_q   <= 1'b0;
    end else if (take) begin
      syn_q <= syn_next;
      par_q <= par_next;
      cnt_q <= cnt_q + 1'b1;
      if (frame_done) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fecc_decode.sv
module fecc_decode
  import fecc_pkg::*;
#(
  parameter int FRAME_WORDS = FRAME_WORDS_D,
  parameter int ECC_WORD    = ECC_WORD_D
) (
  input  logic [POS_W-1:0] syn,
  input  logic             par,
  output fecc_status_e     status,
  output logic [IDX_W-1:0] loc_word,
  output logic [BIT_W-1:0] loc_bit
);
  localparam int FRAME_BITS = FRAME_WORDS * WORD_W;
  localparam int RSV_LO     = ECC_WORD * WORD_W;

  logic [POS_W:0]   back;
  logic [BIT_W-1:0] chk_k;

  always_comb begin
    back  = unpos(syn, FRAME_BITS, RSV_LO);
    chk_k = '0;
    for (int k = 0; k < CHK_BITS; k++)
      if (syn[k]) chk_k = BIT_W'(k);
  end

  always_comb begin
    status   = ST_OK;
    loc_word = '0;
    loc_bit  = '0;
    if (!par) begin
      status = (syn == '0) ? ST_OK : ST_DOUBLE;
    end else if (syn == '0) begin
      status   = ST_SINGLE;
      loc_word = IDX_W'(ECC_WORD);
      loc_bit  = BIT_W'(CHK_BITS);
    end else if ($countones(syn) == 1) begin
      status   = ST_SINGLE;
      loc_word = IDX_W'(ECC_WORD);
      loc_bit  = chk_k;
    end else if (back[POS_W]) begin
      status   = ST_SINGLE;
      loc_word = back[POS_W-1:BIT_W];
      loc_bit  = back[BIT_W-1:0];
    end else begin
      status = ST_DOUBLE;
    end
  end
endmodule

// File: rtl/frame_ecc_check.sv
module frame_ecc_check
  import fecc_pkg::*;
#(
  parameter int FRAME_WORDS = FRAME_WORDS_D,
  parameter int ECC_WORD    = ECC_WORD_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [IDX_W-1:0]  in_index,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [IDX_W-1:0]  res_word,
  output logic [BIT_W-1:0]  res_bit
);
  logic [POS_W-1:0] syn_part, syn_next;
  logic             par_part, par_next, frame_done;
  fecc_status_e     dec_status;
  logic [IDX_W-1:0] dec_word;
  logic [BIT_W-1:0] dec_bit;

  fecc_pos_xor #(.ECC_WORD(ECC_WORD)) u_pos (
    .word(in_word), .index(in_index), .syn_part(syn_part), .par_part(par_part)
  );

  fecc_accum #(.FRAME_WORDS(FRAME_WORDS)) u_acc (
    .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .in_ready(in_ready),
    .syn_part(syn_part), .par_part(par_part),
    .syn_next(syn_next), .par_next(par_next), .frame_done(frame_done)
  );

  fecc_decode #(.FRAME_WORDS(FRAME_WORDS), .ECC_WORD(ECC_WORD)) u_dec (
    .syn(syn_next), .par(par_next),
    .status(dec_status), .loc_word(dec_word), .loc_bit(dec_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= ST_OK;
      res_word   <= '0;
      res_bit    <= '0;
    end else begin
      res_valid <= frame_done;
      if (frame_done) begin
        res_status <= dec_status;
        res_word   <= dec_word;
        res_bit    <= dec_bit;
      end
    end
  end
endmodule

// File: rtl/frame_ecc_check_chk.sv
module frame_ecc_check_chk #(
  parameter int FRAME_WORDS = 101
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sof,
  input logic       in_valid,
  input logic       in_ready,
  input logic       res_valid,
  input logic [1:0] res_status,
  input logic [6:0] res_word,
  input logic [4:0] res_bit
);
  logic [7:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    seen <= '0;
    else if (sof)                  seen <= '0;
    else if (in_valid && in_ready) seen <= seen + 1'b1;
  end

  // R5
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R1
  full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> seen == 8'(FRAME_WORDS));

  // R2
  ready_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  // R2
  sof_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (in_ready || sof));

  // R6
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_status != 2'd3);

  // R10
  loc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 2'd1) |-> (res_word == '0 && res_bit == '0));

  // R8
  loc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'd1) |-> res_word < 7'(FRAME_WORDS));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_status) && $stable(res_word) && $stable(res_bit)));
endmodule

bind frame_ecc_check frame_ecc_check_chk #(.FRAME_WORDS(FRAME_WORDS)) chk_i (.*);

// File: tb/frame_ecc_check_tb.sv
`timescale 1ns/1ps
module frame_ecc_check_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, sof = 1'b0, in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [6:0]  in_index = '0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [6:0]  res_word;
  logic [4:0]  res_bit;

  int n_chk = 0, n_fail = 0, early = 0;
  logic [31:0] frm [101];

  always #10 clk = ~clk;

  frame_ecc_check dut_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_index(in_index), .res_valid(res_valid),
    .res_status(res_status), .res_word(res_word), .res_bit(res_bit)
  );

  typedef struct packed {
    logic [7:0] seed;
    logic [1:0] nf;
    logic [6:0] w0; logic [4:0] b0;
    logic [6:0] w1; logic [4:0] b1;
    logic [6:0] w2; logic [4:0] b2;
    logic [1:0] est;
    logic [6:0] ew; logic [4:0] eb;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{8'd1,  2'd0, 7'd0,  5'd0,  7'd0,  5'd0, 7'd0, 5'd0, 2'd0, 7'd0,   5'd0},
    '{8'd2,  2'd1, 7'd17, 5'd5,  7'd0,  5'd0, 7'd0, 5'd0, 2'd1, 7'd17,  5'd5},
    '{8'd3,  2'd1, 7'd0,  5'd0,  7'd0,  5'd0, 7'd0, 5'd0, 2'd1, 7'd0,   5'd0},
    '{8'd4,  2'd1, 7'd64, 5'd0,  7'd0,  5'd0, 7'd0, 5'd0, 2'd1, 7'd64,  5'd0},
    '{8'd5,  2'd1, 7'd50, 5'd3,  7'd0,  5'd0, 7'd0, 5'd0, 2'd1, 7'd50,  5'd3},
    '{8'd6,  2'd1, 7'd50, 5'd12, 7'd0,  5'd0, 7'd0, 5'd0, 2'd1, 7'd50,  5'd12},
    '{8'd7,  2'd1, 7'd100,5'd31, 7'd0,  5'd0, 7'd0, 5'd0, 2'd1, 7'd100, 5'd31},
    '{8'd8,  2'd2, 7'd3,  5'd4,  7'd90, 5'd1, 7'd0, 5'd0, 2'd2, 7'd0,   5'd0},
    '{8'd9,  2'd2, 7'd50, 5'd0,  7'd50, 5'd7, 7'd0, 5'd0, 2'd2, 7'd0,   5'd0},
    '{8'd10, 2'd3, 7'd48, 5'd10, 7'd2,  5'd8, 7'd0, 5'd3, 2'd2, 7'd0,   5'd0},
    '{8'd11, 2'd3, 7'd96, 5'd0,  7'd8,  5'd3, 7'd0, 5'd3, 2'd2, 7'd0,   5'd0},
    '{8'd12, 2'd1, 7'd50, 5'd20, 7'd0,  5'd0, 7'd0, 5'd0, 2'd1, 7'd50,  5'd20},
    '{8'd13, 2'd2, 7'd4,  5'd0,  7'd8,  5'd0, 7'd0, 5'd0, 2'd2, 7'd0,   5'd0}
  };

  // Position map as stated in R4.
  function automatic logic [11:0] bpos(input int f);
    logic [11:0] v;
    v = f[11:0];
    if ($countones(v) > 1) return v;
    else if (f < 256)      return 12'hF00 | v;
    else                   return 12'hE00 | (v >> 4);
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Build an encoded frame following R3.
  task automatic build_frame(input logic [7:0] seed);
    logic [31:0] x;
    logic [11:0] syn;
    logic        p;
    x = {24'd0, seed} * 32'd2654435761 + 32'd1;
    for (int w = 0; w < 101; w++) begin
      x = x * 32'd1103515245 + 32'd12345;
      frm[w] = x ^ {x[15:0], x[31:16]};
    end
    frm[50][12:0] = '0;
    syn = '0;
    for (int w = 0; w < 101; w++)
      for (int b = 0; b < 32; b++)
        if (frm[w][b] && !(w == 50 && b < 13)) syn = syn ^ bpos(w * 32 + b);
    frm[50][11:0] = syn;
    p = 1'b0;
    for (int w = 0; w < 101; w++) p = p ^ (^frm[w]);
    frm[50][12] = p;
  endtask

  task automatic send_frame(input bit gaps);
    early = 0;
    @(negedge clk); sof = 1'b1; in_valid = 1'b0;
    @(negedge clk); sof = 1'b0;
    for (int i = 0; i < 101; i++) begin
      if (gaps && (i % 7) == 3) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_word = frm[i]; in_index = i[6:0];
      @(negedge clk);
      if (i < 100 && res_valid) early++;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check_eq("R2 in_ready in reset", in_ready, 0);
    check_eq("R6 status in reset", res_status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R2 in_ready before sof", in_ready, 0);
    check_eq("R5 res_valid idle", res_valid, 0);
    // words offered before any sof are ignored
    in_valid = 1'b1; in_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check_eq("R2 no result from unaccepted words", res_valid, 0);

    for (int i = 0; i < 13; i++) begin
      vec_t v;
      int fa;
      v = VECS[i];
      build_frame(v.seed);
      if (v.nf >= 1) frm[v.w0][v.b0] = ~frm[v.w0][v.b0];
      if (v.nf >= 2) frm[v.w1][v.b1] = ~frm[v.w1][v.b1];
      if (v.nf >= 3) frm[v.w2][v.b2] = ~frm[v.w2][v.b2];
      send_frame(i == 1);
      fa = int'(v.w0) * 32 + int'(v.b0);
      if (v.est == 2'd0)                                  tag = "R3 R7";
      else if (v.nf == 2'd3)                              tag = "R11";
      else if (v.nf == 2'd2)                              tag = "R10";
      else if (v.w0 == 7'd50 && v.b0 < 5'd13)             tag = "R9";
      else if ($countones(fa[11:0]) <= 1)                 tag = "R4";
      else if (i == 1)                                    tag = "R1";
      else                                                tag = "R8";
      check_eq($sformatf("R5 res_valid vec%0d", i), res_valid, 1);
      check_eq($sformatf("%s status vec%0d", tag, i), res_status, v.est);
      check_eq($sformatf("%s word vec%0d", tag, i), res_word, v.ew);
      check_eq($sformatf("%s bit vec%0d", tag, i), res_bit, v.eb);
      check_eq($sformatf("R2 in_ready closed vec%0d", i), in_ready, 0);
      check_eq($sformatf("R5 no early result vec%0d", i), early, 0);
      @(negedge clk);
      check_eq($sformatf("R5 strobe one cycle vec%0d", i), res_valid, 0);
    end

    // Words offered after the frame completes are ignored, result held.
    in_valid = 1'b1; in_word = 32'h0000_0001; in_index = 7'd0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_eq("R2 in_ready stays low", in_ready, 0);
      check_eq("R5 no strobe while closed", res_valid, 0);
    end
    in_valid = 1'b0;
    check_eq("R5 status held", res_status, 2);

    // sof in the same cycle as a valid word: not taken.
    @(negedge clk); sof = 1'b1; in_valid = 1'b1;
    #1 check_eq("R2 in_ready low during sof", in_ready, 0);
    @(negedge clk); sof = 1'b0; in_valid = 1'b0;

    // Abort a partial corrupted frame with sof, then a clean frame.
    build_frame(8'd20);
    frm[5][9] = ~frm[5][9];
    for (int i = 0; i < 40; i++) begin
      in_valid = 1'b1; in_word = frm[i]; in_index = i[6:0];
      @(negedge clk);
      if (res_valid) early++;
    end
    in_valid = 1'b0;
    check_eq("R2 no result from partial frame", early, 0);
    build_frame(8'd20);
    send_frame(1'b0);
    check_eq("R2 sof clears partial frame", res_status, 0);
    check_eq("R5 res_valid after restart", res_valid, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule